// File: doc/BRIEF.md
# Pulse Burst Generator

This block emits a finite train of square pulses on one output pin each time it receives a start strobe. The pulse rate comes from the block clock through a power-of-two divider: with a divide select of x, each pulse spends 2^x clock cycles high and then 2^x cycles low. The pulse frequency is therefore the clock rate divided by 2^x × 2. The number of pulses in a train is set by an 8-bit length value. A busy output is high while a train is running, so that controlling logic can tell when the train has finished.

When no train is running, the pin is driven low. A force-high input drives the pin high at all times, so the pin can also serve as a simple general-purpose output. Deasserting the enable input, or entering power save, stops the pulse logic. Either one cuts short any train in progress. The length and divide values are captured when a train starts, so the controlling logic may change them while a train is running.

Top module: `pulse_burst_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, busy is 0. With force_high at 0, pulse_out is also 0.
- R2: A start pulse is accepted when enable is 1, power_save is 0, busy is 0 and burst_len is non-zero. In the cycle after the accepting edge, busy is 1 and pulse_out is 1.
- R3: An accepted train with divide select x and length y produces exactly y pulses. Each pulse is high for 2^x cycles and then low for 2^x cycles, so pulse_out is high for 2^x × y cycles in total. Busy stays 1 for exactly 2 × 2^x × y cycles and then returns to 0.
- R4: Changes to div_sel or burst_len while busy is 1 do not alter the train in progress.
- R5: A start pulse received while busy is 1 is ignored. The running train keeps its original length and timing, and no second train follows it.
- R6: A start pulse with burst_len equal to 0 produces no pulses, and busy stays 0.
- R7: When force_high is 1, pulse_out is 1, whatever the train state. A train that is running continues, and busy still reports it.
- R8: When busy is 0 and force_high is 0, pulse_out is 0.
- R9: If enable falls to 0, or power_save rises to 1, during a train, busy and pulse_out are 0 from the next cycle on.
- R10: A start pulse given while enable is 0, or while power_save is 1, starts no train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the source clock that is divided for the pulses |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Enables the pulse logic; 0 holds the logic idle |
| force_high | input | 1 | Drives pulse_out high at all times |
| power_save | input | 1 | Power save; the pulse logic is held idle while it is 1 |
| div_sel | input | 3 | Divide select x; each half-period lasts 2^x cycles |
| burst_len | input | 8 | Number of pulses in a train, y |
| start | input | 1 | One-cycle strobe that requests a train |
| pulse_out | output | 1 | Pulse output pin |
| busy | output | 1 | Read-only status; 1 while a train is running |

## Verification
The hardest situations to reach from the ports are the ones in the middle of a train: a second start pulse, new div_sel and burst_len values, or an abort. Each of these must arrive on a chosen cycle while the train is running. The bench drives each train through a single task. That task can apply one such event on a chosen busy cycle and then keep measuring pulses, high time and busy time until busy falls. A table of divide and length pairs covers the basic timing, from a one-cycle half-period up to the 128-cycle one and the 255-pulse length.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    // Width of the divide select; half-periods reach 2^(2^DIV_W - 1) cycles.
    localparam int DIV_W = 3;
    // Width of the train length.
    localparam int LEN_W = 8;
    // Width of the half-period counter, sized for the largest half-period minus one.
    localparam int CNT_W = (2 ** DIV_W) - 1;
    // Largest half-period in cycles.
    localparam int MAX_HALF = 1 << CNT_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] len;
    } burst_cfg_t;

    typedef struct packed {
        logic launch;
        logic abort;
    } burst_cmd_t;

    // Terminal count of the half-period counter for a given divide select.
    function automatic logic [CNT_W-1:0] half_last(input logic [DIV_W-1:0] d);
        int span;
        span = (1 << d) - 1;
        return CNT_W'(span);
    endfunction

endpackage

// File: rtl/pbg_cmd_gate.sv
module pbg_cmd_gate
    import pbg_pkg::*;
(
    input  logic             enable,
    input  logic             power_save,
    input  logic             start,
    input  logic             busy,
    input  logic [LEN_W-1:0] burst_len,
    output burst_cmd_t       cmd
);

    logic live;
    logic len_nz;

    always_comb begin
        live       = enable && !power_save;
        len_nz     = |burst_len;
        cmd.abort  = !live;
        cmd.launch = live && start && !busy && len_nz;
    end

endmodule

// File: rtl/pbg_phase_timer.sv
module pbg_phase_timer
    import pbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             phase_done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last       = half_last(div);
        phase_done = run && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || phase_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pbg_burst_ctrl.sv
module pbg_burst_ctrl
    import pbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  burst_cmd_t       cmd,
    input  burst_cfg_t       cfg_in,
    input  logic             phase_done,
    output logic [DIV_W-1:0] div_q,
    output logic             busy,
    output logic             wave
);

    phase_e           state_q;
    burst_cfg_t       cfg_q;
    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            left_q  <= '0;
        end else if (cmd.abort) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd.launch) begin
                        state_q <= ST_HIGH;
                        cfg_q   <= cfg_in;
                        left_q  <= cfg_in.len;
                    end
                end
                ST_HIGH: begin
                    if (phase_done) begin
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (phase_done) begin
                        left_q  <= left_q - 1'b1;
                        state_q <= (left_q == LEN_W'(1)) ? ST_IDLE : ST_HIGH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        div_q = cfg_q.div;
        busy  = (state_q != ST_IDLE);
        wave  = (state_q == ST_HIGH);
    end

endmodule

// File: rtl/pbg_pin_drive.sv
module pbg_pin_drive (
    input  logic force_high,
    input  logic busy,
    input  logic wave,
    output logic pin
);

    always_comb begin
        pin = force_high || (busy && wave);
    end

endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
    import pbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             force_high,
    input  logic             power_save,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             start,
    output logic             pulse_out,
    output logic             busy
);

    burst_cmd_t       cmd;
    burst_cfg_t       cfg_in;
    logic [DIV_W-1:0] run_div;
    logic             phase_done;
    logic             busy_i;
    logic             wave;

    always_comb begin
        cfg_in.div = div_sel;
        cfg_in.len = burst_len;
    end

    pbg_cmd_gate u_gate (
        .enable     (enable),
        .power_save (power_save),
        .start      (start),
        .busy       (busy_i),
        .burst_len  (burst_len),
        .cmd        (cmd)
    );

    pbg_phase_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (busy_i),
        .div        (run_div),
        .phase_done (phase_done)
    );

    pbg_burst_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .cfg_in     (cfg_in),
        .phase_done (phase_done),
        .div_q      (run_div),
        .busy       (busy_i),
        .wave       (wave)
    );

    pbg_pin_drive u_pin (
        .force_high (force_high),
        .busy       (busy_i),
        .wave       (wave),
        .pin        (pulse_out)
    );

    assign busy = busy_i;

endmodule

// File: rtl/pbg_checker.sv
module pbg_checker
    import pbg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             force_high,
    input logic             power_save,
    input logic [LEN_W-1:0] burst_len,
    input logic             start,
    input logic             pulse_out,
    input logic             busy
);

    logic [CNT_W:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst || !(busy && pulse_out && !force_high)) begin
            hi_run <= '0;
        end else begin
            hi_run <= hi_run + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !busy);

    p_launch_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && enable && !power_save && !busy && burst_len != '0) |=> busy);

    p_half_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        hi_run <= (CNT_W+1)'(MAX_HALF));

    p_zero_len_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && burst_len == '0) |=> !busy);

    p_force_pin_r7: assert property (@(posedge clk) disable iff (rst)
        force_high |-> pulse_out);

    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !force_high) |-> !pulse_out);

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (!enable || power_save) |=> !busy);

endmodule

bind pulse_burst_gen pbg_checker u_pbg_checker (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .force_high (force_high),
    .power_save (power_save),
    .burst_len  (burst_len),
    .start      (start),
    .pulse_out  (pulse_out),
    .busy       (busy)
);

// File: tb/pulse_burst_gen_bench.sv
module pulse_burst_gen_bench;
    import pbg_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic             force_high = 1'b0;
    logic             power_save = 1'b0;
    logic [DIV_W-1:0] div_sel = '0;
    logic [LEN_W-1:0] burst_len = '0;
    logic             start = 1'b0;
    logic             pulse_out;
    logic             busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Results of the last train, and an optional event applied in the middle of it.
    int r_busy, r_rises, r_hi, r_first_busy, r_first_out, r_last_out;
    int p_at, p_kind, p_div, p_len;

    // Train table: {divide select, length}.
    localparam logic [10:0] VEC [7] = '{
        {3'd0, 8'd1}, {3'd0, 8'd5}, {3'd1, 8'd3}, {3'd2, 8'd2},
        {3'd3, 8'd1}, {3'd7, 8'd2}, {3'd0, 8'd255}
    };

    always #2.5 clk = ~clk;

    pulse_burst_gen u_pulse_burst_gen (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .force_high (force_high),
        .power_save (power_save),
        .div_sel    (div_sel),
        .burst_len  (burst_len),
        .start      (start),
        .pulse_out  (pulse_out),
        .busy       (busy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    // Starts a train and measures it until busy falls.
    // p_kind: 0 none, 1 new start with new values, 2 enable off, 3 power save on.
    task automatic run_burst(input int d, input int l);
        int n;
        int prev;
        div_sel   = DIV_W'(d);
        burst_len = LEN_W'(l);
        start     = 1'b1;
        tick();
        start = 1'b0;
        r_busy = 0; r_rises = 0; r_hi = 0;
        r_first_busy = int'(busy);
        r_first_out  = int'(pulse_out);
        prev = 0;
        n = 0;
        while (busy && n < 70000) begin
            n++;
            r_busy++;
            if (pulse_out && prev == 0) r_rises++;
            if (pulse_out) r_hi++;
            prev = int'(pulse_out);
            if (n == p_at) begin
                case (p_kind)
                    1: begin start = 1'b1; div_sel = DIV_W'(p_div); burst_len = LEN_W'(p_len); end
                    2: enable = 1'b0;
                    3: power_save = 1'b1;
                    default: ;
                endcase
            end
            tick();
            start = 1'b0;
        end
        r_last_out = int'(pulse_out);
        enable     = 1'b1;
        power_save = 1'b0;
        p_at       = -1;
        p_kind     = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        p_at = -1;
        p_kind = 0;
        #1;
        tick();
        tick();
        // R1: idle while reset is held
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(pulse_out == 1'b0, "R1 pin in reset", int'(pulse_out), 0);
        rst = 1'b0;
        enable = 1'b1;
        tick();
        check(busy == 1'b0 && pulse_out == 1'b0, "R1 after release", int'({busy, pulse_out}), 0);

        // Table walk: R2 and R3
        foreach (VEC[i]) begin
            int d;
            int l;
            int h;
            d = int'(VEC[i][10:8]);
            l = int'(VEC[i][7:0]);
            h = 1 << d;
            run_burst(d, l);
            check(r_first_busy == 1 && r_first_out == 1, "R2 first cycle", r_first_busy + r_first_out, 2);
            check(r_rises == l, "R3 pulse count", r_rises, l);
            check(r_hi == h * l, "R3 high time", r_hi, h * l);
            check(r_busy == 2 * h * l, "R3 busy time", r_busy, 2 * h * l);
            check(r_last_out == 0, "R8 pin after train", r_last_out, 0);
            tick();
        end

        // R4 and R5: new start and new values mid-train are ignored
        p_at = 2; p_kind = 1; p_div = 0; p_len = 5;
        run_burst(1, 2);
        check(r_busy == 8, "R4 R5 busy time", r_busy, 8);
        check(r_rises == 2, "R5 pulse count", r_rises, 2);
        check(r_hi == 4, "R4 high time", r_hi, 4);
        tick();
        tick();
        check(busy == 1'b0, "R5 no second train", int'(busy), 0);

        // R6: zero length
        burst_len = '0;
        start = 1'b1;
        tick();
        start = 1'b0;
        check(busy == 1'b0, "R6 busy", int'(busy), 0);
        check(pulse_out == 1'b0, "R6 pin", int'(pulse_out), 0);

        // R7: forced high while idle and while a train runs
        force_high = 1'b1;
        tick();
        check(pulse_out == 1'b1, "R7 idle forced", int'(pulse_out), 1);
        run_burst(0, 3);
        check(r_busy == 6, "R7 train continues", r_busy, 6);
        check(r_hi == 6, "R7 pin held", r_hi, 6);
        force_high = 1'b0;
        tick();
        check(pulse_out == 1'b0, "R8 released", int'(pulse_out), 0);

        // R9: abort by enable and by power save
        p_at = 3; p_kind = 2;
        run_burst(1, 4);
        check(r_busy == 3, "R9 enable abort", r_busy, 3);
        check(r_last_out == 0, "R9 pin after enable abort", r_last_out, 0);
        tick();
        p_at = 5; p_kind = 3;
        run_burst(2, 3);
        check(r_busy == 5, "R9 power save abort", r_busy, 5);
        check(r_last_out == 0, "R9 pin after power save abort", r_last_out, 0);
        tick();

        // R10: start refused while disabled or in power save
        enable = 1'b0;
        burst_len = 8'd3;
        start = 1'b1;
        tick();
        start = 1'b0;
        check(busy == 1'b0, "R10 disabled", int'(busy), 0);
        check(pulse_out == 1'b0, "R8 disabled pin", int'(pulse_out), 0);
        enable = 1'b1;
        power_save = 1'b1;
        start = 1'b1;
        tick();
        start = 1'b0;
        check(busy == 1'b0, "R10 power save", int'(busy), 0);
        power_save = 1'b0;
        tick();

        // R1: reset in the middle of a train
        div_sel = 3'd2;
        burst_len = 8'd4;
        start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        check(busy == 1'b0 && pulse_out == 1'b0, "R1 mid-train reset", int'({busy, pulse_out}), 0);
        rst = 1'b0;
        tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule